// File: doc/BRIEF.md
# Port-Group Forwarding Mask Resolver

This block decides where a switched frame may go. It keeps one shared table of port-group masks. For each frame it reads three entries from that table and ANDs them to give the egress port mask. The first entry is a destination group. It comes either from the MAC-table hit index or from a fixed flood group chosen by the frame class. The second entry is an aggregation group selected by the frame's 4-bit link-aggregation code. The third entry is a source group, selected by the ingress port, which limits where that port may forward.

Every mask has one bit per physical port plus one more bit for the CPU. The CPU bit sits at the position equal to the number of physical ports. Software loads the table through a simple write port and checks it through a registered read port. The lookup path is pipelined: it accepts one frame per clock and delivers each result a fixed two cycles later.

Top module: `fwd_mask_resolver`

## Requirements
- R1: After reset, every table entry is zero, `out_valid` and `out_mask` are zero, and `cfg_rdata` is zero.
- R2: A write with `cfg_wr` high and `cfg_addr` below 80 plus `N_PORTS` stores `cfg_wdata` in that entry. `cfg_rdata` shows the entry addressed on the previous clock edge, as it stood before any write on that same edge.
- R3: A write to an address at or above the table depth changes no entry. A read of such an address returns zero.
- R4: When `in_hit` is 1, the destination entry is the one at `in_dest_idx` (0 to 63), and `in_class` has no effect.
- R5: When `in_hit` is 0, the destination entry is a flood group chosen by `in_class`, and `in_dest_idx` has no effect. The mapping is: class 0 (unknown unicast) uses index 60, class 1 (broadcast and non-IP multicast) uses 61, class 2 (IPv4 multicast) uses 62, and class 3 (IPv6 multicast) uses 63.
- R6: The aggregation entry is at index 64 plus `in_aggr`, which covers indices 64 to 79.
- R7: The source entry is at index 80 plus `in_port`. An ingress port number at or above `N_PORTS` gives a source mask of zero.
- R8: `out_mask` is the bitwise AND of the destination, aggregation and source entries. Bit `N_PORTS` is the CPU bit and follows the same AND rule.
- R9: A frame presented with `in_valid` at clock edge k produces `out_valid` and its mask at edge k+2. Frames may arrive on every cycle. When `out_valid` is low, `out_mask` is zero.
- R10: A table write at edge k is seen by a frame sampled at edge k+1 or later. A frame sampled at edge k itself still sees the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Table write strobe |
| cfg_addr | input | 7 | Table entry address for write and read |
| cfg_wdata | input | N_PORTS+1 | Mask to write |
| cfg_rdata | output | N_PORTS+1 | Registered read of the entry addressed on the previous edge |
| in_valid | input | 1 | Frame lookup request |
| in_port | input | PORT_W | Ingress port number |
| in_hit | input | 1 | MAC-table hit flag |
| in_dest_idx | input | 6 | Destination group index on a hit |
| in_class | input | 2 | Flood class on a miss |
| in_aggr | input | 4 | Link-aggregation code |
| out_valid | output | 1 | Result valid |
| out_mask | output | N_PORTS+1 | Egress port mask, CPU bit at the top |

## Verification
Lookup results are due on the second rising edge after the frame is sampled. Configuration reads are due on the first rising edge after the address is sampled. The bench drives inputs on falling edges and samples outputs on falling edges. For a streamed burst, it therefore compares the result of frame i at the falling edge where frame i+2 is driven. A configuration read is compared one falling edge after its address is set. The write-ordering check puts a write and a frame on the same edge and then repeats the frame on the following edge. It expects the old mask for the first frame and the new mask for the repeat.

// File: rtl/pgid_pkg.sv
package pgid_pkg;

    typedef enum logic [1:0] {
        FLOOD_UNKNOWN_UC = 2'd0,
        FLOOD_BCAST_MC   = 2'd1,
        FLOOD_IPV4_MC    = 2'd2,
        FLOOD_IPV6_MC    = 2'd3
    } flood_class_e;

    localparam int DEST_SPAN    = 64;
    localparam int AGGR_BASE    = 64;
    localparam int AGGR_SPAN    = 16;
    localparam int SRC_BASE     = 80;
    localparam int GRP_CPU_ONLY = 59;
    localparam int GRP_UC       = 60;
    localparam int GRP_MC       = 61;
    localparam int GRP_IP4      = 62;
    localparam int GRP_IP6      = 63;
    localparam int ADDR_W       = 7;

endpackage

// File: rtl/pgid_index.sv
module pgid_index
    import pgid_pkg::*;
#(
    parameter int N_PORTS = 11,
    parameter int PORT_W  = 4
) (
    input  logic              hit,
    input  logic [5:0]        dest_idx,
    input  logic [1:0]        cls,
    input  logic [3:0]        aggr,
    input  logic [PORT_W-1:0] port,
    output logic [ADDR_W-1:0] dst_sel,
    output logic [ADDR_W-1:0] agg_sel,
    output logic [ADDR_W-1:0] src_sel,
    output logic              src_ok
);

    function automatic logic [ADDR_W-1:0] flood_group(input logic [1:0] c);
        case (flood_class_e'(c))
            FLOOD_UNKNOWN_UC: flood_group = ADDR_W'(GRP_UC);
            FLOOD_BCAST_MC:   flood_group = ADDR_W'(GRP_MC);
            FLOOD_IPV4_MC:    flood_group = ADDR_W'(GRP_IP4);
            default:          flood_group = ADDR_W'(GRP_IP6);
        endcase
    endfunction

    always_comb begin
        dst_sel = hit ? {1'b0, dest_idx} : flood_group(cls);
        agg_sel = ADDR_W'(AGGR_BASE) + ADDR_W'(aggr);
        src_ok  = (32'(port) < N_PORTS);
        src_sel = src_ok ? ADDR_W'(SRC_BASE) + ADDR_W'(port) : ADDR_W'(SRC_BASE);
    end

endmodule

// File: rtl/pgid_table.sv
module pgid_table
    import pgid_pkg::*;
#(
    parameter int N_PORTS = 11,
    parameter int MASK_W  = N_PORTS + 1,
    parameter int DEPTH   = SRC_BASE + N_PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] cfg_rdata,
    input  logic [ADDR_W-1:0] dst_sel,
    input  logic [ADDR_W-1:0] agg_sel,
    input  logic [ADDR_W-1:0] src_sel,
    output logic [MASK_W-1:0] dst_mask,
    output logic [MASK_W-1:0] agg_mask,
    output logic [MASK_W-1:0] src_mask
);

    typedef struct packed {
        logic [DEPTH-1:0][MASK_W-1:0] ent;
        logic [MASK_W-1:0]            rdata;
    } tbl_t;

    tbl_t st_d, st_q;

    function automatic logic [MASK_W-1:0] fetch(input tbl_t s, input logic [ADDR_W-1:0] a);
        logic [MASK_W-1:0] v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (32'(a) == i) v = s.ent[i];
        end
        return v;
    endfunction

    always_comb begin
        st_d       = st_q;
        st_d.rdata = fetch(st_q, cfg_addr);
        for (int i = 0; i < DEPTH; i++) begin
            if (cfg_wr && 32'(cfg_addr) == i) st_d.ent[i] = cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign dst_mask  = fetch(st_q, dst_sel);
    assign agg_mask  = fetch(st_q, agg_sel);
    assign src_mask  = fetch(st_q, src_sel);

    // R3: an address past the table always reads back as zero
    p_oor_read_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(cfg_addr) >= DEPTH) |=> (cfg_rdata == '0));

    // R2: a write followed by a read of the same address returns the written mask
    p_write_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && 32'(cfg_addr) < DEPTH) ##1 ($stable(cfg_addr) && !cfg_wr)
        |=> (cfg_rdata == $past(cfg_wdata, 2)));

endmodule

// File: rtl/pgid_pipe.sv
module pgid_pipe #(
    parameter int MASK_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              src_ok,
    input  logic [MASK_W-1:0] dst_mask,
    input  logic [MASK_W-1:0] agg_mask,
    input  logic [MASK_W-1:0] src_mask,
    output logic              out_valid,
    output logic [MASK_W-1:0] out_mask
);

    typedef struct packed {
        logic              s1_valid;
        logic [MASK_W-1:0] s1_dst;
        logic [MASK_W-1:0] s1_agg;
        logic [MASK_W-1:0] s1_src;
        logic              s2_valid;
        logic [MASK_W-1:0] s2_mask;
    } pipe_t;

    pipe_t pp_d, pp_q;

    always_comb begin
        pp_d          = pp_q;
        pp_d.s1_valid = in_valid;
        pp_d.s1_dst   = in_valid ? dst_mask : '0;
        pp_d.s1_agg   = in_valid ? agg_mask : '0;
        pp_d.s1_src   = (in_valid && src_ok) ? src_mask : '0;
        pp_d.s2_valid = pp_q.s1_valid;
        pp_d.s2_mask  = pp_q.s1_valid ? (pp_q.s1_dst & pp_q.s1_agg & pp_q.s1_src) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pp_q <= '0;
        else        pp_q <= pp_d;
    end

    assign out_valid = pp_q.s2_valid;
    assign out_mask  = pp_q.s2_mask;

    // R9: a request yields a valid result exactly two edges later
    p_latency_two_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    // R9: no request, no result two edges later
    p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R9: idle output carries no mask
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_mask == '0));

    // R8: the result never grants a port outside the sampled aggregation mask
    p_within_aggr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 ((out_mask & ~$past(agg_mask, 2)) == '0));

endmodule

// File: rtl/fwd_mask_resolver.sv
module fwd_mask_resolver
    import pgid_pkg::*;
#(
    parameter int N_PORTS = 11,
    parameter int MASK_W  = N_PORTS + 1,
    parameter int PORT_W  = $clog2(N_PORTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [6:0]        cfg_addr,
    input  logic [MASK_W-1:0] cfg_wdata,
    output logic [MASK_W-1:0] cfg_rdata,
    input  logic              in_valid,
    input  logic [PORT_W-1:0] in_port,
    input  logic              in_hit,
    input  logic [5:0]        in_dest_idx,
    input  logic [1:0]        in_class,
    input  logic [3:0]        in_aggr,
    output logic              out_valid,
    output logic [MASK_W-1:0] out_mask
);

    localparam int DEPTH = SRC_BASE + N_PORTS;

    logic [ADDR_W-1:0] dst_sel, agg_sel, src_sel;
    logic              src_ok;
    logic [MASK_W-1:0] dst_mask, agg_mask, src_mask;

    pgid_index #(.N_PORTS(N_PORTS), .PORT_W(PORT_W)) u_index (
        .hit(in_hit), .dest_idx(in_dest_idx), .cls(in_class), .aggr(in_aggr),
        .port(in_port), .dst_sel(dst_sel), .agg_sel(agg_sel), .src_sel(src_sel),
        .src_ok(src_ok)
    );

    pgid_table #(.N_PORTS(N_PORTS), .MASK_W(MASK_W), .DEPTH(DEPTH)) u_table (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .dst_sel(dst_sel), .agg_sel(agg_sel), .src_sel(src_sel),
        .dst_mask(dst_mask), .agg_mask(agg_mask), .src_mask(src_mask)
    );

    pgid_pipe #(.MASK_W(MASK_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_ok(src_ok),
        .dst_mask(dst_mask), .agg_mask(agg_mask), .src_mask(src_mask),
        .out_valid(out_valid), .out_mask(out_mask)
    );

    // R7: an ingress port beyond the physical range forwards nowhere
    p_bad_port_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && 32'(in_port) >= N_PORTS) |-> ##2 (out_mask == '0));

    // R8: the result is confined to the source group of the ingress port
    p_within_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 ((out_mask & ~$past(src_mask, 2)) == '0));

endmodule

// File: tb/fwd_mask_resolver_test.sv
module fwd_mask_resolver_test;

    localparam int NP = 11;
    localparam int MW = NP + 1;
    localparam int PW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic [6:0]    cfg_addr = '0;
    logic [MW-1:0] cfg_wdata = '0;
    logic [MW-1:0] cfg_rdata;
    logic          in_valid = 1'b0;
    logic [PW-1:0] in_port = '0;
    logic          in_hit = 1'b0;
    logic [5:0]    in_dest_idx = '0;
    logic [1:0]    in_class = '0;
    logic [3:0]    in_aggr = '0;
    logic          out_valid;
    logic [MW-1:0] out_mask;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fwd_mask_resolver #(.N_PORTS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
        .in_port(in_port), .in_hit(in_hit), .in_dest_idx(in_dest_idx),
        .in_class(in_class), .in_aggr(in_aggr), .out_valid(out_valid),
        .out_mask(out_mask)
    );

    typedef struct packed {
        logic [3:0]  port;
        logic        hit;
        logic [5:0]  idx;
        logic [1:0]  cls;
        logic [3:0]  aggr;
        logic [11:0] expect_mask;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'd0,  1'b1, 6'd5,  2'd3, 4'd0,  12'h020},  // R4 hit, class ignored
        '{4'd5,  1'b1, 6'd5,  2'd0, 4'd0,  12'h000},  // R7 own port blocked
        '{4'd1,  1'b1, 6'd20, 2'd0, 4'd1,  12'h050},  // R6 aggr code 1
        '{4'd2,  1'b0, 6'd5,  2'd0, 4'd0,  12'hFFB},  // R5 class 0, idx ignored
        '{4'd2,  1'b0, 6'd0,  2'd1, 4'd15, 12'h00B},  // R5 class 1, R6 code 15
        '{4'd3,  1'b0, 6'd0,  2'd2, 4'd0,  12'h00F},  // R5 class 2
        '{4'd4,  1'b0, 6'd0,  2'd3, 4'd0,  12'h00F},  // R5 class 3
        '{4'd0,  1'b1, 6'd59, 2'd0, 4'd0,  12'h800},  // R8 CPU bit
        '{4'd10, 1'b0, 6'd0,  2'd0, 4'd15, 12'h80F},  // R7 last port
        '{4'd11, 1'b1, 6'd0,  2'd0, 4'd0,  12'h000},  // R7 port out of range
        '{4'd0,  1'b1, 6'd40, 2'd0, 4'd0,  12'h000}   // R4 unwritten group
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input int a, input logic [MW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cfg_read(input int a, output logic [MW-1:0] d);
        @(negedge clk);
        cfg_addr = 7'(a);
        @(negedge clk);
        d = cfg_rdata;
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid = vld; in_port = v.port; in_hit = v.hit;
        in_dest_idx = v.idx; in_class = v.cls; in_aggr = v.aggr;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [MW-1:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", 32'(out_valid), 0);
        check("R1 out_mask after reset", 32'(out_mask), 0);
        cfg_read(60, rd);
        check("R1 entry 60 after reset", 32'(rd), 0);

        for (int i = 0; i < NP; i++) cfg_write(i, MW'(1) << i);
        cfg_write(20, 12'h0F0);
        cfg_write(59, 12'h800);
        cfg_write(60, 12'hFFF);
        cfg_write(61, 12'h0FF);
        cfg_write(62, 12'hF0F);
        cfg_write(63, 12'h00F);
        for (int i = 64; i < 80; i++) cfg_write(i, 12'hFFF);
        cfg_write(65, 12'hF5F);
        cfg_write(79, 12'h80F);
        for (int p = 0; p < NP; p++) cfg_write(80 + p, ~(MW'(1) << p));
        cfg_write(83, 12'h00F);

        cfg_read(20, rd);
        check("R2 readback entry 20", 32'(rd), 32'h0F0);
        cfg_read(83, rd);
        check("R2 readback entry 83", 32'(rd), 32'h00F);
        cfg_write(100, 12'hABC);
        cfg_read(100, rd);
        check("R3 read past table", 32'(rd), 0);
        cfg_read(90, rd);
        check("R3 last entry untouched", 32'(rd), 32'hBFF);

        // streamed burst: result of vector i checked when vector i+2 is driven
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R9 out_valid in burst", 32'(out_valid), 1);
                check("R8 burst mask", 32'(out_mask), 32'(VECS[i-2].expect_mask));
            end
            if (i < NV) drive(VECS[i], 1'b1);
            else        drive(VECS[0], 1'b0);
        end
        @(negedge clk);
        check("R9 idle out_valid", 32'(out_valid), 0);
        check("R9 idle out_mask", 32'(out_mask), 0);

        // R10: write and frame on the same edge, then the frame again
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 7'd30; cfg_wdata = 12'h003;
        drive('{4'd5, 1'b1, 6'd30, 2'd0, 4'd0, 12'h000}, 1'b1);
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        drive(VECS[0], 1'b0);
        check("R10 same-edge frame sees old entry", 32'(out_mask), 0);
        @(negedge clk);
        check("R10 next frame sees new entry", 32'(out_mask), 32'h003);
        check("R10 next frame valid", 32'(out_valid), 1);
        finish_run();
    end

endmodule